// File: doc/BRIEF.md
# Multilevel Carrier PWM Modulator

This block drives the switches of one phase leg of a diode-clamped multilevel inverter. A parameter sets the leg to three or five output levels. The block builds a stack of triangular carriers, one fewer than the number of levels. All carriers come from one shared up/down counter and sit in adjacent amplitude bands that together cover the reference range.

A signed reference sample is compared against every carrier. The number of carriers it exceeds is the output level. That level selects which switches of the clamped leg conduct: a window of consecutive switches that slides down the leg as the level falls.

A 2-bit input selects how the carriers are phased against each other. The carrier period can be changed while the block runs; a new value takes effect at the next counter zero. A one-cycle strobe marks each carrier peak, and the reference is sampled at that peak.

Top module: `mlpwm_leg_modulator`

## Requirements
- R1: With NC = LEVELS-1 carriers and period P, a counter c steps by one per cycle from 0 up to P and back down to 0, so one carrier period is 2P cycles. Carrier k (k = 0 is the lowest band) has the value (k - NC/2)*P + s, where s is c, or P - c when that carrier is mirrored. `level_o` is the count of carriers that the held reference is strictly greater than. It is registered, so it shows the counter value of one cycle earlier.
- R2: With `mode_i` = 0, and also with the spare code 3, no carrier is mirrored, so all carriers rise and fall together.
- R3: With `mode_i` = 1, the carriers below zero (k < NC/2) are mirrored, and the carriers above zero are not.
- R4: With `mode_i` = 2, every odd-numbered carrier (k = 1, 3, ...) is mirrored, so each carrier runs opposite to its neighbours.
- R5: A held reference above the top of the carrier range gives a level of NC, and one below the bottom gives level 0, for the whole carrier period.
- R6: In the three-level leg, `gate_o` bit i drives switch i+1. Level 2 turns on bits 0 and 1, level 1 turns on bits 1 and 2, and level 0 turns on bits 2 and 3.
- R7: In the five-level leg, level L turns on the four consecutive bits from 4-L to 7-L. So level 4 gives 8'h0F and level 0 gives 8'hF0.
- R8: `peak_o` is high for exactly one cycle, the cycle after the counter equals P. The reference is sampled at that same clock edge and is held unchanged until the next peak.
- R9: `period_i` and `mode_i` are taken when the counter is zero, and also while the block is disabled. A period of 0 is treated as 1.
- R10: While reset is asserted, and whenever `en_i` is low, every gate is off. `gate_o` goes to zero in the same cycle that `en_i` falls. In the cycle after a disabled cycle, `level_o` and `peak_o` are 0 and the counter restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low forces all gates off |
| ref_i | input | RW | Signed reference sample |
| mode_i | input | 2 | Carrier disposition: 0 in phase, 1 split at zero, 2 alternate, 3 as 0 |
| period_i | input | CW | Carrier half-period P in cycles |
| gate_o | output | 2*(LEVELS-1) | Switch gates, bit i drives switch i+1 |
| level_o | output | $clog2(LEVELS) | Current output level, 0 is the lowest |
| peak_o | output | 1 | One-cycle strobe after each carrier peak |

## Verification
Any wrong internal state reaches the ports in the next cycle. A counter that steps or turns around wrongly moves `peak_o` and changes the level pattern within one carrier period. A mirrored carrier in the wrong band shifts the edges of the level pulses at the first reference value that falls inside that band. A reference held past its peak, or taken too early, shows as a level that differs from the band count of the sampled value during the rest of the period. A wrong gate window shows as soon as the level reaches the affected value.

// File: rtl/mlpwm_pkg.sv
`timescale 1ns/1ps
package mlpwm_pkg;

    typedef enum logic [1:0] {
        DISP_SAME  = 2'd0,
        DISP_SPLIT = 2'd1,
        DISP_ALT   = 2'd2,
        DISP_SPARE = 2'd3
    } disp_e;

    // True when carrier idx of nc runs opposite to the base slope
    function automatic logic carrier_mirrored(input disp_e mode,
                                              input int unsigned idx,
                                              input int unsigned nc);
        case (mode)
            DISP_SPLIT: return (idx < nc / 2);
            DISP_ALT:   return ((idx % 2) == 1);
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mlpwm_tri_counter.sv
`timescale 1ns/1ps
module mlpwm_tri_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [CW-1:0] period_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] per_o,
    output logic          peak_o,
    output logic          valley_o
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] per;
        logic          up;
    } tri_st_t;

    tri_st_t st_d, st_q;
    logic [CW-1:0] per_safe;

    always_comb begin
        per_safe = (period_i == '0) ? ONE : period_i;
        st_d     = st_q;
        if (!en_i) begin
            st_d.cnt = '0;
            st_d.up  = 1'b1;
            st_d.per = per_safe;
        end else begin
            if (st_q.cnt == '0) begin
                st_d.per = per_safe;
            end
            if (st_q.cnt == st_q.per) begin
                st_d.cnt = st_q.cnt - ONE;
                st_d.up  = 1'b0;
            end else if (st_q.cnt == '0) begin
                st_d.cnt = ONE;
                st_d.up  = 1'b1;
            end else if (st_q.up) begin
                st_d.cnt = st_q.cnt + ONE;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.per <= ONE;
            st_q.up  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o    = st_q.cnt;
    assign per_o    = st_q.per;
    assign peak_o   = (st_q.cnt == st_q.per);
    assign valley_o = (st_q.cnt == '0);

endmodule

// File: rtl/mlpwm_carrier_cmp.sv
`timescale 1ns/1ps
module mlpwm_carrier_cmp
    import mlpwm_pkg::*;
#(
    parameter int NC = 4,
    parameter int CW = 8,
    parameter int RW = 12,
    parameter int LW = 3
) (
    input  disp_e                 mode_i,
    input  logic signed [RW-1:0]  ref_i,
    input  logic        [CW-1:0]  cnt_i,
    input  logic        [CW-1:0]  per_i,
    output logic        [LW-1:0]  level_o
);
    localparam int W = ((RW > CW + 4) ? RW : CW + 4) + 2;

    logic signed [W-1:0] ref_x, per_x, cnt_x;
    logic [NC-1:0]       hit;

    assign ref_x = {{(W-RW){ref_i[RW-1]}}, ref_i};
    assign per_x = {{(W-CW){1'b0}}, per_i};
    assign cnt_x = {{(W-CW){1'b0}}, cnt_i};

    for (genvar k = 0; k < NC; k++) begin : g_band
        localparam logic signed [W-1:0] OFS = W'(k - NC / 2);
        logic signed [W-1:0] base, slope, carrier;
        assign base    = per_x * OFS;
        assign slope   = carrier_mirrored(mode_i, k, NC) ? (per_x - cnt_x) : cnt_x;
        assign carrier = base + slope;
        assign hit[k]  = (ref_x > carrier);
    end

    always_comb begin
        level_o = '0;
        for (int i = 0; i < NC; i++) begin
            level_o = level_o + LW'(hit[i]);
        end
    end

endmodule

// File: rtl/mlpwm_gate_map.sv
`timescale 1ns/1ps
module mlpwm_gate_map #(
    parameter int NC = 4,
    parameter int LW = 3
) (
    input  logic [LW-1:0]   level_i,
    output logic [2*NC-1:0] gate_o
);
    // Level L conducts through switches NC-L .. 2*NC-1-L (bit index)
    for (genvar j = 0; j < 2 * NC; j++) begin : g_sw
        if (j < NC) begin : g_upper
            assign gate_o[j] = (level_i >= LW'(NC - j));
        end else begin : g_lower
            assign gate_o[j] = (level_i <= LW'(2 * NC - 1 - j));
        end
    end

endmodule

// File: rtl/mlpwm_leg_modulator.sv
`timescale 1ns/1ps
module mlpwm_leg_modulator
    import mlpwm_pkg::*;
#(
    parameter int LEVELS = 5,
    parameter int CW     = 8,
    parameter int RW     = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en_i,
    input  logic signed [RW-1:0]        ref_i,
    input  logic [1:0]                  mode_i,
    input  logic [CW-1:0]               period_i,
    output logic [2*(LEVELS-1)-1:0]     gate_o,
    output logic [$clog2(LEVELS)-1:0]   level_o,
    output logic                        peak_o
);
    localparam int NC = LEVELS - 1;
    localparam int GW = 2 * NC;
    localparam int LW = $clog2(LEVELS);

    typedef struct packed {
        logic [RW-1:0] sref;
        logic [1:0]    mode;
        logic [LW-1:0] lvl;
        logic [GW-1:0] gate;
        logic          pk;
    } leg_st_t;

    leg_st_t st_d, st_q;

    logic [CW-1:0] cnt_w, per_w;
    logic          at_peak, at_valley;
    logic [LW-1:0] lvl_now;
    logic [GW-1:0] gate_now;
    logic [RW-1:0] ref_held;

    assign ref_held = st_q.sref;

    mlpwm_tri_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .period_i (period_i),
        .cnt_o    (cnt_w),
        .per_o    (per_w),
        .peak_o   (at_peak),
        .valley_o (at_valley)
    );

    mlpwm_carrier_cmp #(.NC(NC), .CW(CW), .RW(RW), .LW(LW)) u_cmp (
        .mode_i  (disp_e'(st_q.mode)),
        .ref_i   ($signed(ref_held)),
        .cnt_i   (cnt_w),
        .per_i   (per_w),
        .level_o (lvl_now)
    );

    mlpwm_gate_map #(.NC(NC), .LW(LW)) u_map (
        .level_i (lvl_now),
        .gate_o  (gate_now)
    );

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.sref = ref_i;
            st_d.mode = mode_i;
            st_d.lvl  = '0;
            st_d.gate = '0;
            st_d.pk   = 1'b0;
        end else begin
            if (at_valley) st_d.mode = mode_i;
            if (at_peak)   st_d.sref = ref_i;
            st_d.lvl  = lvl_now;
            st_d.gate = gate_now;
            st_d.pk   = at_peak;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o  = en_i ? st_q.gate : '0;
    assign level_o = st_q.lvl;
    assign peak_o  = st_q.pk;

endmodule

// File: rtl/mlpwm_leg_checker.sv
`timescale 1ns/1ps
module mlpwm_leg_checker #(
    parameter int LEVELS = 5,
    parameter int CW     = 8,
    parameter int RW     = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      en_i,
    input logic [2*(LEVELS-1)-1:0]   gate_o,
    input logic [$clog2(LEVELS)-1:0] level_o,
    input logic                      peak_o,
    input logic [CW-1:0]             cnt_i,
    input logic [CW-1:0]             per_i,
    input logic [RW-1:0]             sref_i
);
    localparam int NC = LEVELS - 1;

    logic en_prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_prev_q <= 1'b0;
        else        en_prev_q <= en_i;
    end

    // R6 R7
    gate_window_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && en_prev_q) |-> ($countones(gate_o) == NC));

    // R5
    level_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(level_o) <= NC));

    // R10
    idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_prev_q) |-> (level_o == '0 && !peak_o));

    // R8
    peak_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peak_o |=> !peak_o);

    // R8
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && cnt_i != per_i) |=> $stable(sref_i));

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_i != '0) && (cnt_i <= per_i));

endmodule

bind mlpwm_leg_modulator mlpwm_leg_checker #(.LEVELS(LEVELS), .CW(CW), .RW(RW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .gate_o  (gate_o),
    .level_o (level_o),
    .peak_o  (peak_o),
    .cnt_i   (cnt_w),
    .per_i   (per_w),
    .sref_i  (ref_held)
);

// File: tb/tb_mlpwm_leg_modulator.sv
`timescale 1ns/1ps
module tb_mlpwm_leg_modulator;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic signed [11:0] ref_s = '0;
    logic [1:0]        mode_s = '0;
    logic [7:0]        per_s = 8'd8;

    logic [7:0] gate5;  logic [2:0] lvl5;  logic pk5;
    logic [3:0] gate3;  logic [1:0] lvl3;  logic pk3;

    int total = 0, bad = 0;
    bit run_cmp = 0;
    string ltag = "R1";

    // model state
    int m_cnt = 0, m_up = 1, m_per = 1, m_ref = 0, m_mode = 0;
    int e_l5 = 0, e_l3 = 0, e_pk = 0, e_g5 = 0, e_g3 = 0;

    always #2.5 clk = ~clk;

    mlpwm_leg_modulator #(.LEVELS(5), .CW(8), .RW(12)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .ref_i(ref_s), .mode_i(mode_s),
        .period_i(per_s), .gate_o(gate5), .level_o(lvl5), .peak_o(pk5));

    mlpwm_leg_modulator #(.LEVELS(3), .CW(8), .RW(12)) dut3 (
        .clk(clk), .rst_n(rst_n), .en_i(en), .ref_i(ref_s), .mode_i(mode_s),
        .period_i(per_s), .gate_o(gate3), .level_o(lvl3), .peak_o(pk3));

    function automatic int lvl_of(int r, int c, int p, int md, int nc);
        int n = 0;
        for (int k = 0; k < nc; k++) begin
            bit mir;
            int car;
            mir = (md == 1 && k < nc / 2) || (md == 2 && (k % 2) == 1);
            car = (k - nc / 2) * p + (mir ? p - c : c);
            if (r > car) n++;
        end
        return n;
    endfunction

    function automatic int gate_of(int l, int nc);
        int g = 0;
        for (int j = 0; j < 2 * nc; j++)
            if (j >= nc - l && j <= 2 * nc - 1 - l) g |= (1 << j);
        return g;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle model
    always @(posedge clk) begin
        int n_cnt, n_up, npk;
        if (!rst_n) begin
            m_cnt = 0; m_up = 1; m_per = 1; m_ref = 0; m_mode = 0;
            e_l5 = 0; e_l3 = 0; e_pk = 0; e_g5 = 0; e_g3 = 0;
        end else if (!en) begin
            e_l5 = 0; e_l3 = 0; e_pk = 0; e_g5 = 0; e_g3 = 0;
            m_cnt = 0; m_up = 1;
            m_per = (per_s == 0) ? 1 : int'(per_s);
            m_ref = int'(ref_s); m_mode = int'(mode_s);
        end else begin
            e_l5 = lvl_of(m_ref, m_cnt, m_per, m_mode, 4);
            e_l3 = lvl_of(m_ref, m_cnt, m_per, m_mode, 2);
            e_g5 = gate_of(e_l5, 4);
            e_g3 = gate_of(e_l3, 2);
            npk  = (m_cnt == m_per) ? 1 : 0;
            e_pk = npk;
            if (npk == 1)       begin n_cnt = m_cnt - 1; n_up = 0; end
            else if (m_cnt == 0) begin n_cnt = 1; n_up = 1; end
            else if (m_up == 1) begin n_cnt = m_cnt + 1; n_up = 1; end
            else                begin n_cnt = m_cnt - 1; n_up = 0; end
            if (m_cnt == 0) begin
                m_per = (per_s == 0) ? 1 : int'(per_s);
                m_mode = int'(mode_s);
            end
            if (npk == 1) m_ref = int'(ref_s);
            m_cnt = n_cnt; m_up = n_up;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (run_cmp) begin
            check({ltag, " level5"}, int'(lvl5), e_l5);
            check({ltag, " level3"}, int'(lvl3), e_l3);
            check(en ? "R7 gates5" : "R10 gates5", int'(gate5), en ? e_g5 : 0);
            check(en ? "R6 gates3" : "R10 gates3", int'(gate3), en ? e_g3 : 0);
            check("R8 peak5", int'(pk5), e_pk);
            check("R8 peak3", int'(pk3), e_pk);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sweep(int lo, int hi, int hold);
        for (int r = lo; r <= hi; r++) begin
            ref_s = 12'(r);
            tick(hold);
        end
    endtask

    initial begin
        int pcount;
        int seed;
        // reset state
        repeat (3) @(negedge clk);
        check("R10 reset level5", int'(lvl5), 0);
        check("R10 reset gates5", int'(gate5), 0);
        check("R10 reset gates3", int'(gate3), 0);
        check("R10 reset peak", int'(pk5), 0);
        tick();
        rst_n = 1'b1;
        run_cmp = 1;
        tick(2);

        // in-phase carriers
        ltag = "R2"; mode_s = 2'd0; per_s = 8'd8; en = 1'b1;
        sweep(-20, 20, 7);
        // split at zero
        ltag = "R3"; mode_s = 2'd1; per_s = 8'd6;
        sweep(-15, 15, 5);
        // alternate
        ltag = "R4"; mode_s = 2'd2; per_s = 8'd5;
        sweep(-12, 12, 6);
        // spare code behaves as in-phase
        ltag = "R2"; mode_s = 2'd3; per_s = 8'd4;
        sweep(-9, 9, 5);

        // saturation
        ltag = "R5"; mode_s = 2'd0; per_s = 8'd8;
        ref_s = 12'sd500; tick(40);
        @(negedge clk);
        check("R5 top level5", int'(lvl5), 4);
        check("R5 top level3", int'(lvl3), 2);
        check("R7 top gates5", int'(gate5), 8'h0F);
        check("R6 top gates3", int'(gate3), 4'h3);
        ref_s = -12'sd500; tick(40);
        @(negedge clk);
        check("R5 bottom level5", int'(lvl5), 0);
        check("R7 bottom gates5", int'(gate5), 8'hF0);
        check("R6 bottom gates3", int'(gate3), 4'hC);
        ref_s = 12'sd1; tick(40);
        @(negedge clk);
        check("R6 mid gates3", int'(gate3), int'(lvl3) == 1 ? 4'h6 : gate_of(int'(lvl3), 2));

        // period zero acts as one, period three
        ltag = "R9"; per_s = 8'd0; ref_s = 12'sd0;
        tick(30);
        pcount = 0;
        repeat (20) begin @(negedge clk); if (pk5) pcount++; end
        check("R9 period0 peaks", pcount, 10);
        tick();
        per_s = 8'd3; tick(30);
        pcount = 0;
        repeat (24) begin @(negedge clk); if (pk5) pcount++; end
        check("R8 period3 peaks", pcount, 4);

        // enable low clears gates at once
        tick();
        ref_s = 12'sd2;
        en = 1'b0;
        @(negedge clk);
        check("R10 gates5 off", int'(gate5), 0);
        check("R10 gates3 off", int'(gate3), 0);
        tick(3);
        en = 1'b1;
        tick(20);

        // mixed stimulus
        ltag = "R1"; seed = 7;
        for (int i = 0; i < 3000; i++) begin
            seed = seed * 1103515245 + 12345;
            if ((i % 37) == 0) ref_s = 12'(((seed >>> 16) % 41) - 20);
            if ((i % 211) == 0) mode_s = 2'((seed >>> 20) & 3);
            if ((i % 313) == 0) per_s = 8'(((seed >>> 8) & 7) + 2);
            if ((i % 499) == 0) en = 1'b0;
            else if ((i % 499) == 3) en = 1'b1;
            tick();
        end
        en = 1'b1;
        tick(10);
        run_cmp = 0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #900000;
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule